// File: doc/BRIEF.md
# Dual-Address Masked I2C Address Filter

This block sits behind a bit-level I2C slave receiver and decides whether a received address byte is meant for this slave. It can answer to one 7-bit address or to two. A first stage compares the upper seven bits of the byte against a single compare value under a single mask. A second stage then compares the address exactly and decides between ACK and NACK, and it reports which of the two configured addresses was hit.

In two-address mode the shared mask keeps only the bit positions where the two addresses agree. Other bus addresses can therefore pass the first stage. The exact second stage removes those false hits before any ACK goes out. Writing zero as the second address turns two-address mode off.

The block also covers low-power use. With wake capability enabled and the device asleep, a matching address is held: SCL is kept low with no ACK, and a single-cycle wake request goes out, until a wake acknowledge arrives. With wake capability off, a sleeping slave NACKs every address. A disabled block drives all outputs low and ignores the bus.

Top module: `i2c_dual_addr_filter`

## Requirements
- R1: Only bits [7:1] of the received byte are compared as the address. Bit 0 is the direction (1 = read) and is reported unchanged on `rsp_read` with the response.
- R2: With `addr_b` equal to zero (one-address mode), a byte is ACKed exactly when bits [7:1] equal `addr_a`, and `rsp_sel_b` is 0.
- R3: With a non-zero `addr_b` (two-address mode), a byte is ACKed exactly when bits [7:1] equal `addr_a` or `addr_b`. `rsp_sel_b` is 1 only when they equal `addr_b`.
- R4: In two-address mode, an address that agrees with the shared mask (mask = bitwise NOT of `addr_a` XOR `addr_b`) but equals neither address is NACKed. Example: `addr_a`=0x24, `addr_b`=0x10, address 0x20.
- R5: For a strobe on `byte_valid` that is accepted for an immediate decision, `rsp_valid` is high for exactly one cycle, in the cycle after the strobe, together with `rsp_ack`, `rsp_sel_b` and `rsp_read`.
- R6: After either configured address changes, the new mask and compare values are in use for every strobe that comes two or more cycles later.
- R7: With `enable`, `asleep` and `wake_cap` high, a byte that would be ACKed raises `scl_hold` in the next cycle, together with a one-cycle `wake_req` pulse, and gives no response. While `scl_hold` is high, further strobes are ignored.
- R8: When `wake_ack` is high while `scl_hold` is high, the next cycle has `scl_hold` low and `rsp_valid` high with `rsp_ack`=1, and the select and direction stored for the held byte.
- R9: While asleep with wake capability, a byte that would be NACKed gets a normal NACK response (R5 timing) with no hold and no wake request.
- R10: While `enable` is low, every output is 0 and strobes have no effect. A hold in progress is dropped and does not return when `enable` rises again.
- R11: With `asleep` high and `wake_cap` low, every address is NACKed with R5 timing, and `scl_hold` stays low.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces outputs to 0 and ignores the bus |
| asleep | input | 1 | Device is in a low-power state |
| wake_cap | input | 1 | Hold and wake on a match while asleep |
| addr_a | input | ADDR_W | Primary address, right-justified |
| addr_b | input | ADDR_W | Secondary address; zero disables two-address mode |
| byte_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received address byte |
| rx_byte | input | ADDR_W+1 | Address in [7:1], direction in [0] |
| wake_ack | input | 1 | Device awake; release a held address |
| rsp_valid | output | 1 | One-cycle pulse: decision outputs are valid |
| rsp_ack | output | 1 | 1 = ACK the address, 0 = NACK |
| rsp_sel_b | output | 1 | 1 = secondary address is active |
| rsp_read | output | 1 | Direction bit of the decided byte |
| scl_hold | output | 1 | Hold SCL low pending wake |
| wake_req | output | 1 | One-cycle wake request pulse |

## Verification
Every decision shows up in the cycle after its strobe, because one register stands between the address byte and the response. The bench drives the strobe on a falling edge for one cycle and reads the response at the next falling edge. It checks one cycle later again to see that the pulse has ended. The configured addresses pass through a change-detect register, so the table walk waits two cycles after each configuration change before it sends a strobe. In the hold sequence, `scl_hold` and `wake_req` are checked one cycle after the strobe, the pulse end and the continued hold a cycle later, and the released ACK one cycle after the `wake_ack` cycle.

// File: rtl/idaf_pkg.sv
package idaf_pkg;

   typedef struct packed {
      logic vld;
      logic ack;
      logic sel_b;
      logic rd;
   } idaf_resp_t;

   localparam idaf_resp_t IDAF_RESP_IDLE = '{vld: 1'b0, ack: 1'b0, sel_b: 1'b0, rd: 1'b0};

endpackage

// File: rtl/idaf_cfg_regs.sv
// Holds the configured addresses and derives the shared compare mask.
// Refreshed whenever either address changes (and once after reset).
module idaf_cfg_regs #(
   parameter int ADDR_W      = 7,
   parameter bit TWO_ADDR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic [ADDR_W-1:0] cfg_a,
   output logic [ADDR_W-1:0] cfg_b,
   output logic [ADDR_W-1:0] cfg_mask,
   output logic              cfg_two
);

   logic [ADDR_W-1:0] b_eff;
   logic [ADDR_W-1:0] mask_nxt;
   logic              two_nxt;
   logic              primed_q;
   logic              changed;

   generate
      if (TWO_ADDR_EN) begin : g_dual
         always_comb begin
            b_eff    = addr_b;
            two_nxt  = |addr_b;
            mask_nxt = two_nxt ? ~(addr_a ^ addr_b) : '1;
         end
      end else begin : g_single
         always_comb begin
            b_eff    = '0;
            two_nxt  = 1'b0;
            mask_nxt = '1;
         end
      end
   endgenerate

   assign changed = !primed_q || (addr_a != cfg_a) || (b_eff != cfg_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         cfg_a    <= '0;
         cfg_b    <= '0;
         cfg_mask <= '1;
         cfg_two  <= 1'b0;
      end else if (changed) begin
         primed_q <= 1'b1;
         cfg_a    <= addr_a;
         cfg_b    <= b_eff;
         cfg_mask <= mask_nxt;
         cfg_two  <= two_nxt;
      end
   end

endmodule

// File: rtl/idaf_prematch.sv
// First stage: masked compare of the received address against one value.
module idaf_prematch #(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] cmp_val,
   input  logic [ADDR_W-1:0] cmp_mask,
   output logic              pre_hit
);

   logic [ADDR_W-1:0] bit_ok;

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         assign bit_ok[i] = !cmp_mask[i] || (rx_addr[i] == cmp_val[i]);
      end
   endgenerate

   assign pre_hit = &bit_ok;

endmodule

// File: rtl/idaf_decide.sv
// Second stage: exact compare, ACK/NACK, active select, hold/wake sequencing.
module idaf_decide
   import idaf_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              sleep_hold,
   input  logic              sleep_nack,
   input  logic              byte_valid,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic              rx_rd,
   input  logic              pre_hit,
   input  logic              cfg_two,
   input  logic [ADDR_W-1:0] cfg_a,
   input  logic [ADDR_W-1:0] cfg_b,
   input  logic              wake_ack,
   output idaf_resp_t        resp,
   output logic              hold_o,
   output logic              wake_o
);

   logic       hit_a;
   logic       hit_b;
   logic       accept;
   logic       sel_b;
   logic       hold_q;
   logic       wake_q;
   logic       pend_sel_q;
   logic       pend_rd_q;
   idaf_resp_t resp_q;

   always_comb begin
      hit_a  = (rx_addr == cfg_a);
      hit_b  = cfg_two && (rx_addr == cfg_b);
      accept = pre_hit && (cfg_two ? (hit_a || hit_b) : 1'b1);
      sel_b  = hit_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         wake_q     <= 1'b0;
         pend_sel_q <= 1'b0;
         pend_rd_q  <= 1'b0;
         resp_q     <= IDAF_RESP_IDLE;
      end else if (!enable) begin
         hold_q     <= 1'b0;
         wake_q     <= 1'b0;
         pend_sel_q <= 1'b0;
         pend_rd_q  <= 1'b0;
         resp_q     <= IDAF_RESP_IDLE;
      end else begin
         wake_q     <= 1'b0;
         resp_q.vld <= 1'b0;
         if (hold_q) begin
            if (wake_ack) begin
               hold_q       <= 1'b0;
               resp_q.vld   <= 1'b1;
               resp_q.ack   <= 1'b1;
               resp_q.sel_b <= pend_sel_q;
               resp_q.rd    <= pend_rd_q;
            end
         end else if (byte_valid) begin
            if (sleep_hold && accept) begin
               hold_q     <= 1'b1;
               wake_q     <= 1'b1;
               pend_sel_q <= sel_b;
               pend_rd_q  <= rx_rd;
            end else begin
               resp_q.vld   <= 1'b1;
               resp_q.ack   <= accept && !sleep_nack;
               resp_q.sel_b <= accept && !sleep_nack && sel_b;
               resp_q.rd    <= rx_rd;
            end
         end
      end
   end

   assign resp   = resp_q;
   assign hold_o = hold_q;
   assign wake_o = wake_q;

endmodule

// File: rtl/i2c_dual_addr_filter.sv
module i2c_dual_addr_filter
   import idaf_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter bit TWO_ADDR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              asleep,
   input  logic              wake_cap,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic              byte_valid,
   input  logic [ADDR_W:0]   rx_byte,
   input  logic              wake_ack,
   output logic              rsp_valid,
   output logic              rsp_ack,
   output logic              rsp_sel_b,
   output logic              rsp_read,
   output logic              scl_hold,
   output logic              wake_req
);

   localparam int BYTE_W = ADDR_W + 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_width
         $error("i2c_dual_addr_filter: ADDR_W must be in 2..10");
      end
   endgenerate

   logic [ADDR_W-1:0] cfg_a;
   logic [ADDR_W-1:0] cfg_b;
   logic [ADDR_W-1:0] cfg_mask;
   logic              cfg_two;
   logic [ADDR_W-1:0] rx_addr;
   logic              rx_rd;
   logic              pre_hit;
   logic              hold_i;
   logic              wake_i;
   idaf_resp_t        resp;

   assign rx_addr = rx_byte[BYTE_W-1:1];
   assign rx_rd   = rx_byte[0];

   idaf_cfg_regs #(.ADDR_W(ADDR_W), .TWO_ADDR_EN(TWO_ADDR_EN)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_a   (addr_a),
      .addr_b   (addr_b),
      .cfg_a    (cfg_a),
      .cfg_b    (cfg_b),
      .cfg_mask (cfg_mask),
      .cfg_two  (cfg_two)
   );

   idaf_prematch #(.ADDR_W(ADDR_W)) u_pre (
      .rx_addr  (rx_addr),
      .cmp_val  (cfg_a),
      .cmp_mask (cfg_mask),
      .pre_hit  (pre_hit)
   );

   idaf_decide #(.ADDR_W(ADDR_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .sleep_hold (asleep && wake_cap),
      .sleep_nack (asleep && !wake_cap),
      .byte_valid (byte_valid),
      .rx_addr    (rx_addr),
      .rx_rd      (rx_rd),
      .pre_hit    (pre_hit),
      .cfg_two    (cfg_two),
      .cfg_a      (cfg_a),
      .cfg_b      (cfg_b),
      .wake_ack   (wake_ack),
      .resp       (resp),
      .hold_o     (hold_i),
      .wake_o     (wake_i)
   );

   always_comb begin
      rsp_valid = enable && resp.vld;
      rsp_ack   = enable && resp.ack;
      rsp_sel_b = enable && resp.sel_b;
      rsp_read  = enable && resp.rd;
      scl_hold  = enable && hold_i;
      wake_req  = enable && wake_i;
   end

endmodule

// File: rtl/idaf_checker.sv
module idaf_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic asleep,
   input logic wake_cap,
   input logic byte_valid,
   input logic wake_ack,
   input logic rsp_valid,
   input logic rsp_ack,
   input logic rsp_sel_b,
   input logic scl_hold,
   input logic wake_req
);

   a_r5_resp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      enable && byte_valid && !scl_hold && !(asleep && wake_cap) |=> rsp_valid || !enable);

   a_r3_sel_implies_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_sel_b |-> rsp_ack);

   a_r7_wake_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   a_r7_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
      enable && scl_hold && !wake_ack |=> scl_hold || !enable);

   a_r7_no_resp_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> !rsp_valid);

   a_r8_release_acks: assert property (@(posedge clk) disable iff (!rst_n)
      enable && scl_hold && wake_ack |=> !enable || (!scl_hold && rsp_valid && rsp_ack));

   a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !scl_hold && !wake_req && !rsp_valid);

   a_r11_no_hold_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_cap && !scl_hold |=> !scl_hold);

endmodule

bind i2c_dual_addr_filter idaf_checker u_idaf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .asleep     (asleep),
   .wake_cap   (wake_cap),
   .byte_valid (byte_valid),
   .wake_ack   (wake_ack),
   .rsp_valid  (rsp_valid),
   .rsp_ack    (rsp_ack),
   .rsp_sel_b  (rsp_sel_b),
   .scl_hold   (scl_hold),
   .wake_req   (wake_req)
);

// File: tb/i2c_dual_addr_filter_bench.sv
`timescale 1ns/1ps
module i2c_dual_addr_filter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       asleep = 1'b0;
   logic       wake_cap = 1'b0;
   logic [6:0] addr_a = 7'h00;
   logic [6:0] addr_b = 7'h00;
   logic       byte_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       wake_ack = 1'b0;
   logic       rsp_valid, rsp_ack, rsp_sel_b, rsp_read, scl_hold, wake_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_dual_addr_filter u_i2c_dual_addr_filter (
      .clk, .rst_n, .enable, .asleep, .wake_cap, .addr_a, .addr_b,
      .byte_valid, .rx_byte, .wake_ack,
      .rsp_valid, .rsp_ack, .rsp_sel_b, .rsp_read, .scl_hold, .wake_req
   );

   typedef struct packed {
      logic [6:0] a;
      logic [6:0] b;
      logic [7:0] byt;
      logic       ack;
      logic       sel;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{7'h24, 7'h00, 8'h48, 1'b1, 1'b0},  // R2 match, write
      '{7'h24, 7'h00, 8'h49, 1'b1, 1'b0},  // R1 direction bit ignored in compare
      '{7'h24, 7'h00, 8'h20, 1'b0, 1'b0},  // R2 miss
      '{7'h24, 7'h10, 8'h48, 1'b1, 1'b0},  // R3 primary
      '{7'h24, 7'h10, 8'h21, 1'b1, 1'b1},  // R3 secondary, read
      '{7'h24, 7'h10, 8'h40, 1'b0, 1'b0},  // R4 false pre-match 0x20
      '{7'h24, 7'h10, 8'h6A, 1'b0, 1'b0},  // R3 masked miss 0x35
      '{7'h51, 7'h50, 8'hA0, 1'b1, 1'b1},  // R6 new pair, secondary
      '{7'h51, 7'h50, 8'hA3, 1'b1, 1'b0},  // R3 primary, read
      '{7'h51, 7'h50, 8'hA4, 1'b0, 1'b0},  // R3 miss 0x52
      '{7'h51, 7'h00, 8'hA0, 1'b0, 1'b0}   // R6 secondary cleared: 0x50 now NACKed
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_byte    = b;
      byte_valid = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rsp_valid", rsp_valid, 0);
      chk("R12 rsp_ack", rsp_ack, 0);
      chk("R12 scl_hold", scl_hold, 0);
      chk("R12 wake_req", wake_req, 0);
      rst_n  = 1'b1;
      enable = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         addr_a = VECS[i].a;
         addr_b = VECS[i].b;
         repeat (2) @(negedge clk);
         send(VECS[i].byt);
         chk($sformatf("R5 valid vec %0d", i), rsp_valid, 1);
         chk($sformatf("R2/R3 ack vec %0d", i), rsp_ack, VECS[i].ack);
         chk($sformatf("R3 sel vec %0d", i), rsp_sel_b, VECS[i].sel);
         chk($sformatf("R1 read vec %0d", i), rsp_read, VECS[i].byt[0]);
         @(negedge clk);
         chk($sformatf("R5 pulse end vec %0d", i), rsp_valid, 0);
      end

      // R7 hold on match while asleep with wake capability
      addr_a = 7'h24; addr_b = 7'h10;
      asleep = 1'b1; wake_cap = 1'b1;
      repeat (2) @(negedge clk);
      send(8'h21);
      chk("R7 hold raised", scl_hold, 1);
      chk("R7 wake pulse", wake_req, 1);
      chk("R7 no response", rsp_valid, 0);
      @(negedge clk);
      chk("R7 wake pulse ends", wake_req, 0);
      chk("R7 hold kept", scl_hold, 1);
      send(8'h48);  // ignored while held
      chk("R7 strobe ignored", rsp_valid, 0);
      chk("R7 hold still", scl_hold, 1);
      wake_ack = 1'b1;
      @(negedge clk);
      wake_ack = 1'b0;
      // R8 release
      chk("R8 hold released", scl_hold, 0);
      chk("R8 valid", rsp_valid, 1);
      chk("R8 ack", rsp_ack, 1);
      chk("R8 sel", rsp_sel_b, 1);
      chk("R8 read", rsp_read, 1);

      // R9 asleep, non-matching byte
      send(8'h40);
      chk("R9 valid", rsp_valid, 1);
      chk("R9 nack", rsp_ack, 0);
      chk("R9 no hold", scl_hold, 0);
      chk("R9 no wake", wake_req, 0);

      // R11 asleep without wake capability
      wake_cap = 1'b0;
      send(8'h48);
      chk("R11 valid", rsp_valid, 1);
      chk("R11 nack", rsp_ack, 0);
      chk("R11 no hold", scl_hold, 0);

      // R10 disabled: strobes ignored
      asleep = 1'b0;
      enable = 1'b0;
      send(8'h48);
      chk("R10 no valid", rsp_valid, 0);
      chk("R10 no ack", rsp_ack, 0);
      enable = 1'b1;
      @(negedge clk);
      chk("R10 nothing latched", rsp_valid, 0);

      // R10 hold dropped by disable
      asleep = 1'b1; wake_cap = 1'b1;
      send(8'h48);
      chk("R10 hold set first", scl_hold, 1);
      enable = 1'b0;
      #0.5;
      chk("R10 outputs low", scl_hold, 0);
      @(negedge clk);
      enable = 1'b1;
      #0.5;
      chk("R10 hold gone", scl_hold, 0);
      @(negedge clk);
      chk("R10 hold stays gone", scl_hold, 0);

      finish_run();
   end

endmodule